// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, day of week, day of month, month, a two-digit year and a century bit. A sub-second divider counts enabled cycles of a 32.768 kHz clock-enable input and advances the seconds field once per `DIV_COUNT` enabled ticks. The hour field runs in either a 12-hour format with an AM/PM flag or a 24-hour format, picked by a mode bit. The day-of-month limit follows the month and the leap-year rule. The leap-year rule uses only the two year digits.

Every field can be loaded through a single-cycle write port. A write to the seconds field also clears the sub-second divider, so a new second starts exactly at the write. The block drives a 1 Hz square wave and four single-cycle strobes for the interrupt and alarm logic. The strobes mark a seconds advance, a new minute, a new hour, and the start of a new month at 00:00:00.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD. Each wraps from 59 to 00 and advances the next field on that wrap.
- R2: In 24-hour mode the hour counts 00 to 23 in BCD. The wrap from 23 to 00 advances the date.
- R3: In 12-hour mode, hour bit 5 is the PM flag and bits 4:0 hold BCD 01 to 12. The order is 12, 01, …, 11. AM11 goes to PM12 (0x32), PM12 goes to PM01 (0x21), and PM11 (0x31) goes to AM12 (0x12). Only the PM11 to AM12 step advances the date.
- R4: A write to field 7 sets the format from data bit 0 (1 = 24-hour, 0 = 12-hour). The write does not change the stored hour value.
- R5: The day of month counts from 01 to a maximum that depends on the month. Feb has 28 days, or 29 when the BCD year is a multiple of 4 (00 counts as one). Apr, Jun, Sep and Nov have 30. All other months have 31. Past the maximum the day returns to 01 and the month advances. The month runs 01 to 12, and its wrap advances the year.
- R6: The day of week (0 to 6) advances with every date advance and wraps from 6 to 0.
- R7: The century bit is month-field bit 7. It toggles when the year wraps from 99 to 00.
- R8: Seconds advance on the `DIV_COUNT`-th enabled tick. A seconds write resets the divider, so the next advance comes exactly `DIV_COUNT` enabled ticks later. The 1 Hz output is high during the first half of each second.
- R9: The strobes are registered and last one cycle. They line up with the updated counter values. A minute strobe always comes with a seconds strobe, an hour strobe with a minute strobe, and a month strobe with an hour strobe.
- R10: A write to a field wins over an advance of that field in the same cycle. The other fields still advance from their old values.
- R11: After reset the time is 00:00:00 in 12-hour mode with the hour at AM12 (0x12). The date is day-of-week 0, 01/01, year 00, century 0.
- R12: Write field select codes are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month (bit 7 = century), 6 year, 7 format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz clock enable |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select (R12) |
| wr_data_i | input | 8 | Write data, packed BCD |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD (bit 5 PM flag in 12-hour mode) |
| wday_o | output | 3 | Day of week 0 to 6 |
| mday_o | output | 6 | Day of month, BCD |
| month_o | output | 5 | Month, BCD |
| century_o | output | 1 | Century bit |
| year_o | output | 8 | Year, BCD |
| mode24_o | output | 1 | 1 = 24-hour format |
| clk_1hz_o | output | 1 | 1 Hz square wave |
| sec_stb_o | output | 1 | Seconds advanced |
| min_stb_o | output | 1 | New minute began |
| hour_stb_o | output | 1 | New hour began |
| month_stb_o | output | 1 | New month began |

## Verification
The bench targets each rollover edge:
- The three 12-hour steps around noon and midnight. A design that carries the day at PM12 instead of PM11 would advance the date twelve hours early.
- Feb 28 and Feb 29 in leap and non-leap years, including year 00. A wrong leap rule would skip or insert a day.
- The Dec 31, year 99 wrap. Missing it would leave the century bit unchanged.

A seconds write is timed against the next strobe; a design that kept the divider phase would advance early. A minute write is placed in the exact cycle of a seconds carry; a design that let the carry win would show the old minute plus one.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_MDAY  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_MODE  = 3'd7
  } rtc_field_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit BCD year divisible by 4
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_days(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic adv_o,
  output logic half_o
);
  localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV_COUNT / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign adv_o  = tick_i && !clr_i && (cnt_q == LAST);
  assign half_o = cnt_q < HALF;

  AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R8
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/rtc_mod60.sv
`timescale 1ns/1ps
module rtc_mod60
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_i,
  input  logic [6:0] wr_data_i,
  output logic [6:0] val_o,
  output logic       carry_o
);
  logic [6:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (wr_i)       val_d = wr_data_i;
    else if (adv_i) val_d = (val_q == 7'h59) ? 7'h00 : 7'(bcd_inc({1'b0, val_q}));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o   = val_q;
  assign carry_o = adv_i && (val_q == 7'h59);

  AST_M60_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_i && val_q == 7'h59) |=> (val_q == 7'h00)); // R1
  AST_M60_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (val_q == $past(wr_data_i))); // R10

endmodule

// File: rtl/rtc_hour.sv
`timescale 1ns/1ps
module rtc_hour
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       mode24_i,
  input  logic       wr_i,
  input  logic [5:0] wr_data_i,
  output logic [5:0] val_o,
  output logic       carry_o
);
  logic [5:0] val_q, nxt, val_d;

  always_comb begin
    if (mode24_i) begin
      nxt = (val_q == 6'h23) ? 6'h00 : 6'(bcd_inc({2'b00, val_q}));
    end else begin
      if (val_q[4:0] == 5'h12)      nxt = {val_q[5], 5'h01};
      else if (val_q[4:0] == 5'h11) nxt = {~val_q[5], 5'h12};
      else                          nxt = {val_q[5], 5'(bcd_inc({3'b000, val_q[4:0]}))};
    end
  end

  always_comb begin
    val_d = val_q;
    if (wr_i)       val_d = wr_data_i;
    else if (adv_i) val_d = nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= 6'h12;
    else         val_q <= val_d;
  end

  assign val_o   = val_q;
  assign carry_o = adv_i && (mode24_i ? (val_q == 6'h23) : (val_q == 6'h31));

  AST_H24_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_i && mode24_i && val_q == 6'h23) |=> (val_q == 6'h00)); // R2
  AST_H12_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_i && !mode24_i && val_q == 6'h31) |=> (val_q == 6'h12)); // R3
  AST_H12_NOON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_i && !mode24_i && val_q == 6'h11) |=> (val_q == 6'h32)); // R3

endmodule

// File: rtl/rtc_date.sv
`timescale 1ns/1ps
module rtc_date
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [2:0] wday_o,
  output logic [5:0] mday_o,
  output logic [4:0] month_o,
  output logic       century_o,
  output logic [7:0] year_o,
  output logic       month_start_o
);
  logic [2:0] wday_q;
  logic [5:0] mday_q, dmax;
  logic [4:0] month_q;
  logic [7:0] year_q;
  logic       century_q;
  logic       wr_wday, wr_mday, wr_month, wr_year;
  logic       last_day, last_month, year_wrap;

  assign wr_wday  = wr_en_i && (wr_sel_i == FLD_WDAY);
  assign wr_mday  = wr_en_i && (wr_sel_i == FLD_MDAY);
  assign wr_month = wr_en_i && (wr_sel_i == FLD_MONTH);
  assign wr_year  = wr_en_i && (wr_sel_i == FLD_YEAR);

  assign dmax       = 6'(month_days(month_q, is_leap(year_q)));
  assign last_day   = adv_i && (mday_q == dmax);
  assign last_month = month_q == 5'h12;
  assign year_wrap  = last_day && last_month;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wday_q    <= '0;
      mday_q    <= 6'h01;
      month_q   <= 5'h01;
      year_q    <= 8'h00;
      century_q <= 1'b0;
    end else begin
      if (wr_wday)    wday_q <= wr_data_i[2:0];
      else if (adv_i) wday_q <= (wday_q == 3'd6) ? 3'd0 : wday_q + 3'd1;

      if (wr_mday)       mday_q <= wr_data_i[5:0];
      else if (last_day) mday_q <= 6'h01;
      else if (adv_i)    mday_q <= 6'(bcd_inc({2'b00, mday_q}));

      if (wr_month)      month_q <= wr_data_i[4:0];
      else if (last_day) month_q <= last_month ? 5'h01 : 5'(bcd_inc({3'b000, month_q}));

      if (wr_year)        year_q <= wr_data_i;
      else if (year_wrap) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);

      if (wr_month)                            century_q <= wr_data_i[7];
      else if (year_wrap && year_q == 8'h99)   century_q <= ~century_q;
    end
  end

  assign wday_o        = wday_q;
  assign mday_o        = mday_q;
  assign month_o       = month_q;
  assign century_o     = century_q;
  assign year_o        = year_q;
  assign month_start_o = last_day;

  AST_FEB_LEAP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_mday && !wr_month && month_q == 5'h02 && mday_q == 6'h29)
      |=> (mday_q == 6'h01 && month_q == 5'h03)); // R5
  AST_WDAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_wday && wday_q == 3'd6) |=> (wday_q == 3'd0)); // R6
  AST_CENTURY_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_month && !wr_mday && month_q == 5'h12 && mday_q == 6'h31 && year_q == 8'h99)
      |=> (century_o != $past(century_o))); // R7

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic [2:0] wday_o,
  output logic [5:0] mday_o,
  output logic [4:0] month_o,
  output logic       century_o,
  output logic [7:0] year_o,
  output logic       mode24_o,
  output logic       clk_1hz_o,
  output logic       sec_stb_o,
  output logic       min_stb_o,
  output logic       hour_stb_o,
  output logic       month_stb_o
);
  localparam int N_MS = 2;  // seconds, minutes

  logic             sec_adv;
  logic [N_MS-1:0]  ms_adv, ms_carry, ms_wr;
  logic [6:0]       ms_val [N_MS];
  logic             hour_carry, month_start;
  logic             mode_q;
  logic             wr_hour, wr_mode;
  logic             sec_stb_q, min_stb_q, hour_stb_q, month_stb_q;

  assign wr_hour = wr_en_i && (wr_sel_i == FLD_HOUR);
  assign wr_mode = wr_en_i && (wr_sel_i == FLD_MODE);

  rtc_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (ms_wr[0]),
    .adv_o  (sec_adv),
    .half_o (clk_1hz_o)
  );

  for (genvar i = 0; i < N_MS; i++) begin : g_ms
    assign ms_wr[i]  = wr_en_i && (wr_sel_i == 3'(i));
    assign ms_adv[i] = (i == 0) ? sec_adv : ms_carry[(i == 0) ? 0 : i - 1];
    rtc_mod60 u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adv_i     (ms_adv[i]),
      .wr_i      (ms_wr[i]),
      .wr_data_i (wr_data_i[6:0]),
      .val_o     (ms_val[i]),
      .carry_o   (ms_carry[i])
    );
  end

  rtc_hour u_hour (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (ms_carry[1]),
    .mode24_i  (mode_q),
    .wr_i      (wr_hour),
    .wr_data_i (wr_data_i[5:0]),
    .val_o     (hour_o),
    .carry_o   (hour_carry)
  );

  rtc_date u_date (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .adv_i         (hour_carry),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .wday_o        (wday_o),
    .mday_o        (mday_o),
    .month_o       (month_o),
    .century_o     (century_o),
    .year_o        (year_o),
    .month_start_o (month_start)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 1'b0;
      sec_stb_q   <= 1'b0;
      min_stb_q   <= 1'b0;
      hour_stb_q  <= 1'b0;
      month_stb_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wr_data_i[0];
      sec_stb_q   <= sec_adv;
      min_stb_q   <= ms_carry[0];
      hour_stb_q  <= ms_carry[1];
      month_stb_q <= month_start;
    end
  end

  assign sec_o       = ms_val[0];
  assign min_o       = ms_val[1];
  assign mode24_o    = mode_q;
  assign sec_stb_o   = sec_stb_q;
  assign min_stb_o   = min_stb_q;
  assign hour_stb_o  = hour_stb_q;
  assign month_stb_o = month_stb_q;

  AST_MIN_IN_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_stb_o |-> sec_stb_o); // R9
  AST_HOUR_IN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_stb_o |-> min_stb_o); // R9
  AST_MONTH_IN_HOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    month_stb_o |-> hour_stb_o); // R9
  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> (mode24_o == $past(wr_data_i[0]) && $stable(hour_o))); // R4

endmodule

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, mday_o;
  logic [2:0] wday_o;
  logic [4:0] month_o;
  logic       century_o, mode24_o, clk_1hz_o;
  logic [7:0] year_o;
  logic       sec_stb_o, min_stb_o, hour_stb_o, month_stb_o;

  rtc_calendar #(.DIV_COUNT(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .month_o(month_o), .century_o(century_o), .year_o(year_o),
    .mode24_o(mode24_o), .clk_1hz_o(clk_1hz_o), .sec_stb_o(sec_stb_o),
    .min_stb_o(min_stb_o), .hour_stb_o(hour_stb_o), .month_stb_o(month_stb_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [5:0] next_hour(input logic [5:0] code, input bit m24);
    int h;
    bit pm;
    if (m24) begin
      h = (from_bcd({2'b00, code}) + 1) % 24;
      return 6'(to_bcd(h));
    end
    pm = code[5];
    h = from_bcd({3'b000, code[4:0]});
    if (h == 12) h = 1;
    else if (h == 11) begin h = 12; pm = !pm; end
    else h = h + 1;
    return {pm, 5'(to_bcd(h))};
  endfunction

  // reference model
  int m_sec, m_min, m_wday, m_mday, m_mon, m_yr, m_div;
  logic [5:0] m_hour;
  bit m_cen, m_mode, s_sec, s_min, s_hour, s_mon;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hour = 6'h12; m_wday = 0; m_mday = 1; m_mon = 1;
      m_yr = 0; m_cen = 0; m_mode = 0; m_div = 0;
      s_sec = 0; s_min = 0; s_hour = 0; s_mon = 0;
    end else begin
      bit wsec, adv, cmin, chour, cday, cmon;
      int n_sec, n_min, n_wday, n_mday, n_mon, n_yr;
      logic [5:0] n_hour;
      bit n_cen, n_mode;
      wsec = wr_en && wr_sel == 3'd0;
      adv = tick && m_div == DIV - 1 && !wsec;
      if (wsec) m_div = 0;
      else if (tick) m_div = (m_div + 1) % DIV;
      cmin = adv && m_sec == 59;
      chour = cmin && m_min == 59;
      cday = chour && (m_mode ? m_hour == 6'h23 : m_hour == 6'h31);
      cmon = cday && m_mday == days_in(m_mon, m_yr);
      n_sec = m_sec; n_min = m_min; n_hour = m_hour; n_wday = m_wday; n_mday = m_mday;
      n_mon = m_mon; n_yr = m_yr; n_cen = m_cen; n_mode = m_mode;
      if (adv) n_sec = (m_sec + 1) % 60;
      if (cmin) n_min = (m_min + 1) % 60;
      if (chour) n_hour = next_hour(m_hour, m_mode);
      if (cday) begin n_wday = (m_wday + 1) % 7; n_mday = m_mday + 1; end
      if (cmon) begin
        n_mday = 1;
        if (m_mon == 12) begin
          n_mon = 1; n_yr = (m_yr + 1) % 100;
          if (m_yr == 99) n_cen = !m_cen;
        end else n_mon = m_mon + 1;
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: n_sec = from_bcd({1'b0, wr_data[6:0]});
          3'd1: n_min = from_bcd({1'b0, wr_data[6:0]});
          3'd2: n_hour = wr_data[5:0];
          3'd3: n_wday = int'(wr_data[2:0]);
          3'd4: n_mday = from_bcd({2'b00, wr_data[5:0]});
          3'd5: begin n_mon = from_bcd({3'b000, wr_data[4:0]}); n_cen = wr_data[7]; end
          3'd6: n_yr = from_bcd(wr_data);
          default: n_mode = wr_data[0];
        endcase
      end
      m_sec = n_sec; m_min = n_min; m_hour = n_hour; m_wday = n_wday; m_mday = n_mday;
      m_mon = n_mon; m_yr = n_yr; m_cen = n_cen; m_mode = n_mode;
      s_sec = adv; s_min = cmin; s_hour = chour; s_mon = cmon;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 sec", {1'b0, sec_o}, to_bcd(m_sec));
      chk("R1 min", {1'b0, min_o}, to_bcd(m_min));
      chk(m_mode ? "R2 hour" : "R3 hour", {2'b00, hour_o}, {2'b00, m_hour});
      chk("R6 wday", {5'b0, wday_o}, 8'(m_wday));
      chk("R5 mday", {2'b00, mday_o}, to_bcd(m_mday));
      chk("R5 month", {3'b000, month_o}, to_bcd(m_mon));
      chk("R5 year", year_o, to_bcd(m_yr));
      chk("R7 century", {7'b0, century_o}, {7'b0, m_cen});
      chk("R4 mode", {7'b0, mode24_o}, {7'b0, m_mode});
      chk("R8 1hz", {7'b0, clk_1hz_o}, {7'b0, m_div < DIV / 2});
      chk("R8 sec_stb", {7'b0, sec_stb_o}, {7'b0, s_sec});
      chk("R9 min_stb", {7'b0, min_stb_o}, {7'b0, s_min});
      chk("R9 hour_stb", {7'b0, hour_stb_o}, {7'b0, s_hour});
      chk("R9 month_stb", {7'b0, month_stb_o}, {7'b0, s_mon});
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
  endtask
  task automatic wr_end();
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic wait_secs(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (sec_stb_o) k++;
    end
  endtask
  // load a time with the divider stopped, then release
  task automatic set_time(input logic [5:0] h, input logic [6:0] m, input logic [6:0] s);
    @(negedge clk); tick = 1'b0;
    wr(3'd2, {2'b00, h});
    wr(3'd1, {1'b0, m});
    wr(3'd0, {1'b0, s});
    wr_end();
    tick = 1'b1;
  endtask
  task automatic set_date(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
    @(negedge clk); tick = 1'b0;
    wr(3'd6, y);
    wr(3'd5, mo);
    wr(3'd4, d);
    wr_end();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 sec", {1'b0, sec_o}, 8'h00);
    chk("R11 hour", {2'b00, hour_o}, 8'h12);
    chk("R11 mday", {2'b00, mday_o}, 8'h01);
    chk("R11 month", {3'b000, month_o}, 8'h01);
    chk("R11 mode", {7'b0, mode24_o}, 8'h00);

    // R1 minute carry, R12 field codes
    set_time(6'h12, 7'h00, 7'h57);
    wait_secs(3);
    chk("R1 sec wrap", {1'b0, sec_o}, 8'h00);
    chk("R1 min carry", {1'b0, min_o}, 8'h01);
    chk("R9 min strobe", {7'b0, min_stb_o}, 8'h01);

    // R3 12-hour steps
    set_time(6'h11, 7'h59, 7'h59);
    wait_secs(1);
    chk("R3 AM11 to PM12", {2'b00, hour_o}, 8'h32);
    chk("R3 no day at noon", {2'b00, mday_o}, 8'h01);
    set_time(6'h32, 7'h59, 7'h59);
    wait_secs(1);
    chk("R3 PM12 to PM01", {2'b00, hour_o}, 8'h21);
    @(negedge clk); tick = 1'b0;
    wr(3'd3, 8'd6);
    wr_end();
    set_time(6'h31, 7'h59, 7'h59);
    wait_secs(1);
    chk("R3 PM11 to AM12", {2'b00, hour_o}, 8'h12);
    chk("R3 day advance", {2'b00, mday_o}, 8'h02);
    chk("R6 wday wrap", {5'b0, wday_o}, 8'h00);

    // R4 mode write keeps the hour
    set_time(6'h05, 7'h10, 7'h00);
    wr(3'd7, 8'h01);
    wr_end();
    chk("R4 mode set", {7'b0, mode24_o}, 8'h01);
    chk("R4 hour kept", {2'b00, hour_o}, 8'h05);

    // R2 24-hour wrap
    set_time(6'h23, 7'h59, 7'h59);
    wait_secs(1);
    chk("R2 23 to 00", {2'b00, hour_o}, 8'h00);
    chk("R2 day advance", {2'b00, mday_o}, 8'h03);
    chk("R6 wday step", {5'b0, wday_o}, 8'h01);

    // R5 month lengths and leap rule
    set_date(8'h23, 8'h02, 8'h28);
    set_time(6'h23, 7'h59, 7'h59);
    wait_secs(1);
    chk("R5 non-leap Feb end", {2'b00, mday_o}, 8'h01);
    chk("R5 to March", {3'b000, month_o}, 8'h03);
    chk("R9 month strobe", {7'b0, month_stb_o}, 8'h01);
    set_date(8'h24, 8'h02, 8'h28);
    set_time(6'h23, 7'h59, 7'h59);
    wait_secs(1);
    chk("R5 leap Feb 29", {2'b00, mday_o}, 8'h29);
    set_time(6'h23, 7'h59, 7'h59);
    wait_secs(1);
    chk("R5 leap Feb end", {3'b000, month_o}, 8'h03);
    set_date(8'h24, 8'h04, 8'h30);
    set_time(6'h23, 7'h59, 7'h59);
    wait_secs(1);
    chk("R5 April end", {3'b000, month_o}, 8'h05);
    set_date(8'h00, 8'h02, 8'h28);
    set_time(6'h23, 7'h59, 7'h59);
    wait_secs(1);
    chk("R5 year 00 leap", {2'b00, mday_o}, 8'h29);

    // R7 century toggle
    set_date(8'h99, 8'h12, 8'h31);
    set_time(6'h23, 7'h59, 7'h59);
    wait_secs(1);
    chk("R7 year wrap", year_o, 8'h00);
    chk("R7 month wrap", {3'b000, month_o}, 8'h01);
    chk("R7 century set", {7'b0, century_o}, 8'h01);

    // R8 seconds write restarts the divider
    wait_secs(1);
    repeat (2) @(negedge clk);
    wr(3'd0, 8'h10);
    wr_end();
    chk("R8 1hz high after write", {7'b0, clk_1hz_o}, 8'h01);
    c = 0;
    do begin @(negedge clk); c++; end while (!sec_stb_o && c < 50);
    chk("R8 divider restart", 8'(c), 8'(DIV));

    // R10 minute write in the seconds-carry cycle
    @(negedge clk); tick = 1'b0;
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h59);
    @(negedge clk); wr_en = 1'b0; tick = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h30;
    wr_end();
    chk("R10 write wins", {1'b0, min_o}, 8'h30);
    chk("R10 sec still wraps", {1'b0, sec_o}, 8'h00);

    // irregular enables
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      tick = (i % 3) != 1;
    end
    tick = 1'b1;
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule